// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block checks a single data-cache tag read back from one way of a set. A tag is given as a high word and a low word, together with the set index address that was used to read it. On a one-cycle valid strobe the block samples all three. One cycle later it presents a registered result. The result holds the 5-bit coherence state code, a one-hot decode of that code, a flag for a code that is not legal, two parity verdicts over the physical tag, the rebuilt physical line address, the bank and set numbers taken from the index, and the replacement-order field.

Error-handling logic uses the block to classify a suspect tag without software having to decode it bit by bit. Only six sparse 5-bit codes are legal states. When the code is not legal, the tag contents are treated as meaningless, so the address parity is neither checked nor reported. The registered outputs keep their values until the next strobe.

Top module: `dtag_state_checker`

## Requirements
- R1: While reset is asserted and after it is released, every output reads zero until the first strobe has been captured.
- R2: `chk_valid_o` is high for exactly the one cycle after a cycle with `tag_valid_i` high, and low otherwise. All result outputs take the new values in that same cycle.
- R3: When `tag_valid_i` is low, no result output changes, whatever the other inputs do.
- R4: `state_oh_o` has exactly one bit set after a capture. Bit 0 is code 0x00 (invalid), bit 1 is 0x0F (coherent shared), bit 2 is 0x13 (non-coherent exclusive clean), bit 3 is 0x19 (non-coherent exclusive dirty), bit 4 is 0x16 (coherent exclusive clean), bit 5 is 0x1C (coherent exclusive dirty), and bit 6 is any other code.
- R5: `state_err_o` is 1 exactly when the captured code is none of the six legal codes.
- R6: For a legal code, `par_fail_o[1]` is 1 when low-tag bit 11 differs from the even parity (XOR) of low-tag bits 39:26.
- R7: For a legal code, `par_fail_o[0]` is 1 when low-tag bit 10 differs from the XOR of low-tag bits 25:13. `addr_err_o` is the OR of both parity bits.
- R8: For an illegal code, `par_fail_o` and `addr_err_o` are 0, whatever the tag bits hold.
- R9: `line_pa_o` is low-tag bits 39:13 placed in bits 39:13, with index bits 12:0 in bits 12:0.
- R10: `bank_o` is {index bit 12, index bit 5}, and `set_o` is index bits 11:6.
- R11: `repl_order_o` is high-tag bits 21:14. Bits 1:0 give the least recently used way number, and bits 7:6 the most recently used.
- R12: `state_code_o` is high-tag bits 29:25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_valid_i | input | 1 | Strobe that captures the tag and index |
| tag_hi_i | input | 32 | High tag word (state, replacement order) |
| tag_lo_i | input | 64 | Low tag word (physical tag, parity bits) |
| index_i | input | 13 | Set index address used for the read |
| chk_valid_o | output | 1 | Result captured in the previous cycle |
| state_code_o | output | 5 | Raw coherence state code |
| state_oh_o | output | 7 | One-hot state decode, bit 6 = illegal |
| state_err_o | output | 1 | Illegal state code |
| addr_err_o | output | 1 | Any physical-tag parity mismatch |
| par_fail_o | output | 2 | Parity mismatch: bit 1 upper range, bit 0 lower range |
| line_pa_o | output | 40 | Rebuilt physical line address |
| bank_o | output | 2 | Bank number from the index |
| set_o | output | 6 | Set number from the index |
| repl_order_o | output | 8 | Replacement order, least recent way in bits 1:0 |

## Verification
The assertions assume that `tag_valid_i` is a clean 0 or 1 at every sampled edge and that the data inputs are known whenever it is high. They also assume that reset is held for at least one edge before any strobe. The bench drives every input on the falling edge and keeps the strobe low throughout reset. It also changes the data inputs freely while the strobe is low, which exercises the hold property against real input activity. Random tags are biased towards the six legal codes and correct parity, and single parity bits are flipped at random, so that both parity paths and the illegal-state gating are reached often.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  localparam int ST_W       = 5;
  localparam int ST_LSB     = 25;
  localparam int RO_W       = 8;
  localparam int RO_LSB     = 14;
  localparam int NUM_LEGAL  = 6;
  localparam int OH_W       = NUM_LEGAL + 1;
  localparam int PAR_UP_BIT = 11;
  localparam int PAR_LO_BIT = 10;
  localparam int PAR_SPLIT  = 26;
  localparam int NUM_RANGES = 2;

  typedef enum logic [ST_W-1:0] {
    ST_INVALID  = 5'h00,
    ST_SHARED   = 5'h0F,
    ST_NCX_CLN  = 5'h13,
    ST_NCX_DRT  = 5'h19,
    ST_CX_CLN   = 5'h16,
    ST_CX_DRT   = 5'h1C
  } coh_state_e;

  // Legal code for a given one-hot slot
  function automatic logic [ST_W-1:0] legal_code(input int slot);
    case (slot)
      0:       legal_code = ST_INVALID;
      1:       legal_code = ST_SHARED;
      2:       legal_code = ST_NCX_CLN;
      3:       legal_code = ST_NCX_DRT;
      4:       legal_code = ST_CX_CLN;
      default: legal_code = ST_CX_DRT;
    endcase
  endfunction

  // Even parity over bits hi..lo of a word
  function automatic logic range_par(input logic [63:0] w, input int hi, input int lo);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) p = p ^ w[i];
    end
    return p;
  endfunction
endpackage

// File: rtl/dtag_state_dec.sv
module dtag_state_dec
  import dtag_pkg::*;
(
  input  logic [ST_W-1:0] code_i,
  output logic [OH_W-1:0] onehot_o,
  output logic            legal_o
);
  logic [NUM_LEGAL-1:0] hit;

  for (genvar g = 0; g < NUM_LEGAL; g++) begin : g_slot
    assign hit[g] = (code_i == legal_code(g));
  end

  assign legal_o  = |hit;
  assign onehot_o = {~legal_o, hit};
endmodule

// File: rtl/dtag_par_chk.sv
module dtag_par_chk
  import dtag_pkg::*;
#(
  parameter int LO_W  = 64,
  parameter int IDX_W = 13,
  parameter int PA_W  = 40
) (
  input  logic [LO_W-1:0]       tag_lo_i,
  input  logic                  legal_i,
  output logic [NUM_RANGES-1:0] fail_o
);
  logic [63:0] word;
  assign word = 64'(tag_lo_i);

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam int HI  = (r == 1) ? PA_W - 1  : PAR_SPLIT - 1;
    localparam int LO  = (r == 1) ? PAR_SPLIT : IDX_W;
    localparam int CHK = (r == 1) ? PAR_UP_BIT : PAR_LO_BIT;
    logic mismatch;
    assign mismatch  = word[CHK] ^ range_par(word, HI, LO);
    assign fail_o[r] = legal_i & mismatch;
  end
endmodule

// File: rtl/dtag_addr_map.sv
module dtag_addr_map
  import dtag_pkg::*;
#(
  parameter int HI_W  = 32,
  parameter int LO_W  = 64,
  parameter int IDX_W = 13,
  parameter int PA_W  = 40
) (
  input  logic [HI_W-1:0]  tag_hi_i,
  input  logic [LO_W-1:0]  tag_lo_i,
  input  logic [IDX_W-1:0] index_i,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       bank_o,
  output logic [5:0]       set_o,
  output logic [RO_W-1:0]  repl_o
);
  localparam int SET_LSB = 6;
  localparam int BANK_LO = 5;

  assign pa_o   = {tag_lo_i[PA_W-1:IDX_W], index_i};
  assign bank_o = {index_i[IDX_W-1], index_i[BANK_LO]};
  assign set_o  = index_i[SET_LSB +: 6];
  assign repl_o = tag_hi_i[RO_LSB +: RO_W];
endmodule

// File: rtl/dtag_state_checker.sv
module dtag_state_checker
  import dtag_pkg::*;
#(
  parameter int HI_W  = 32,
  parameter int LO_W  = 64,
  parameter int IDX_W = 13,
  parameter int PA_W  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_valid_i,
  input  logic [HI_W-1:0]  tag_hi_i,
  input  logic [LO_W-1:0]  tag_lo_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             chk_valid_o,
  output logic [4:0]       state_code_o,
  output logic [6:0]       state_oh_o,
  output logic             state_err_o,
  output logic             addr_err_o,
  output logic [1:0]       par_fail_o,
  output logic [PA_W-1:0]  line_pa_o,
  output logic [1:0]       bank_o,
  output logic [5:0]       set_o,
  output logic [7:0]       repl_order_o
);
  // Named internal events for the checker
  logic                  capture_w;
  logic                  legal_w;
  logic [ST_W-1:0]       code_w;
  logic [OH_W-1:0]       oh_w;
  logic [NUM_RANGES-1:0] pfail_w;
  logic [PA_W-1:0]       pa_w;
  logic [1:0]            bank_w;
  logic [5:0]            set_w;
  logic [RO_W-1:0]       repl_w;

  assign capture_w = tag_valid_i;
  assign code_w    = tag_hi_i[ST_LSB +: ST_W];

  dtag_state_dec u_dec (
    .code_i   (code_w),
    .onehot_o (oh_w),
    .legal_o  (legal_w)
  );

  dtag_par_chk #(.LO_W(LO_W), .IDX_W(IDX_W), .PA_W(PA_W)) u_par (
    .tag_lo_i (tag_lo_i),
    .legal_i  (legal_w),
    .fail_o   (pfail_w)
  );

  dtag_addr_map #(.HI_W(HI_W), .LO_W(LO_W), .IDX_W(IDX_W), .PA_W(PA_W)) u_map (
    .tag_hi_i (tag_hi_i),
    .tag_lo_i (tag_lo_i),
    .index_i  (index_i),
    .pa_o     (pa_w),
    .bank_o   (bank_w),
    .set_o    (set_w),
    .repl_o   (repl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid_o  <= 1'b0;
      state_code_o <= '0;
      state_oh_o   <= '0;
      state_err_o  <= 1'b0;
      addr_err_o   <= 1'b0;
      par_fail_o   <= '0;
      line_pa_o    <= '0;
      bank_o       <= '0;
      set_o        <= '0;
      repl_order_o <= '0;
    end else begin
      chk_valid_o <= capture_w;
      if (capture_w) begin
        state_code_o <= code_w;
        state_oh_o   <= oh_w;
        state_err_o  <= ~legal_w;
        addr_err_o   <= |pfail_w;
        par_fail_o   <= pfail_w;
        line_pa_o    <= pa_w;
        bank_o       <= bank_w;
        set_o        <= set_w;
        repl_order_o <= repl_w;
      end
    end
  end
endmodule

// File: rtl/dtag_state_checker_sva.sv
module dtag_state_checker_sva #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            capture_w,
  input logic            chk_valid_o,
  input logic [4:0]      state_code_o,
  input logic [6:0]      state_oh_o,
  input logic            state_err_o,
  input logic            addr_err_o,
  input logic [1:0]      par_fail_o,
  input logic [PA_W-1:0] line_pa_o,
  input logic [5:0]      set_o,
  input logic [7:0]      repl_order_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> chk_valid_o);  // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_w |=> !chk_valid_o);  // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_w |=> ($stable(line_pa_o) && $stable(state_code_o) && $stable(state_oh_o)
                    && $stable(par_fail_o) && $stable(repl_order_o)));  // R3
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_o |-> ($countones(state_oh_o) == 1));  // R4
  AST_SHARED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_o && state_oh_o[1]) |-> (state_code_o == 5'h0F));  // R4
  AST_ILLEGAL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    state_err_o |-> state_oh_o[6]);  // R5
  AST_NO_PAR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_err_o |-> (!addr_err_o && par_fail_o == 2'b00));  // R8
  AST_SET_IN_PA: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_o |-> (line_pa_o[11:6] == set_o));  // R10
endmodule

bind dtag_state_checker dtag_state_checker_sva #(.PA_W(PA_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .capture_w    (capture_w),
  .chk_valid_o  (chk_valid_o),
  .state_code_o (state_code_o),
  .state_oh_o   (state_oh_o),
  .state_err_o  (state_err_o),
  .addr_err_o   (addr_err_o),
  .par_fail_o   (par_fail_o),
  .line_pa_o    (line_pa_o),
  .set_o        (set_o),
  .repl_order_o (repl_order_o)
);

// File: tb/dtag_state_checker_bench.sv
`timescale 1ns/1ps
module dtag_state_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tag_valid_i = 1'b0;
  logic [31:0] tag_hi_i = '0;
  logic [63:0] tag_lo_i = '0;
  logic [12:0] index_i = '0;
  logic        chk_valid_o;
  logic [4:0]  state_code_o;
  logic [6:0]  state_oh_o;
  logic        state_err_o;
  logic        addr_err_o;
  logic [1:0]  par_fail_o;
  logic [39:0] line_pa_o;
  logic [1:0]  bank_o;
  logic [5:0]  set_o;
  logic [7:0]  repl_order_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dtag_state_checker u_dtag_state_checker (
    .clk(clk), .rst_n(rst_n), .tag_valid_i(tag_valid_i), .tag_hi_i(tag_hi_i),
    .tag_lo_i(tag_lo_i), .index_i(index_i), .chk_valid_o(chk_valid_o),
    .state_code_o(state_code_o), .state_oh_o(state_oh_o), .state_err_o(state_err_o),
    .addr_err_o(addr_err_o), .par_fail_o(par_fail_o), .line_pa_o(line_pa_o),
    .bank_o(bank_o), .set_o(set_o), .repl_order_o(repl_order_o)
  );

  logic [4:0] legal_tab [6] = '{5'h00, 5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};

  function automatic logic [6:0] exp_oh(input logic [4:0] c);
    logic [6:0] r = '0;
    for (int i = 0; i < 6; i++) if (legal_tab[i] == c) r[i] = 1'b1;
    if (r == '0) r[6] = 1'b1;
    return r;
  endfunction

  function automatic logic pcount(input logic [63:0] w, input int hi, input int lo);
    int n = 0;
    for (int i = lo; i <= hi; i++) n += int'(w[i]);
    return n[0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fix_par(input logic [63:0] lo, input bit bad_up, input bit bad_lo);
    logic [63:0] w = lo;
    w[11] = pcount(w, 39, 26) ^ bad_up;
    w[10] = pcount(w, 25, 13) ^ bad_lo;
    return w;
  endfunction

  task automatic apply(input logic [31:0] hi, input logic [63:0] lo, input logic [12:0] idx);
    logic [4:0] code;
    logic legal, up, dn;
    @(negedge clk);
    tag_hi_i = hi; tag_lo_i = lo; index_i = idx; tag_valid_i = 1'b1;
    @(negedge clk);
    tag_valid_i = 1'b0;
    code  = hi[29:25];
    legal = (exp_oh(code)[6] == 1'b0);
    up    = legal && (lo[11] != pcount(lo, 39, 26));
    dn    = legal && (lo[10] != pcount(lo, 25, 13));
    chk("R2 valid",  64'(chk_valid_o),  64'd1);
    chk("R12 code",  64'(state_code_o), 64'(code));
    chk("R4 onehot", 64'(state_oh_o),   64'(exp_oh(code)));
    chk("R5 serr",   64'(state_err_o),  64'(!legal));
    chk("R6 upper",  64'(par_fail_o[1]), 64'(up));
    chk("R7 lower",  64'(par_fail_o[0]), 64'(dn));
    chk("R7 aerr",   64'(addr_err_o),   64'(up | dn));
    if (!legal) chk("R8 gated", 64'({addr_err_o, par_fail_o}), 64'd0);
    chk("R9 pa",     64'(line_pa_o),    64'({lo[39:13], idx}));
    chk("R10 bank",  64'(bank_o),       64'({idx[12], idx[5]}));
    chk("R10 set",   64'(set_o),        64'(idx[11:6]));
    chk("R11 repl",  64'(repl_order_o), 64'(hi[21:14]));
  endtask

  task automatic hold_check;
    logic [39:0] pa0 = line_pa_o;
    logic [6:0]  oh0 = state_oh_o;
    logic [1:0]  pf0 = par_fail_o;
    logic [7:0]  ro0 = repl_order_o;
    @(negedge clk);
    tag_hi_i = $urandom; tag_lo_i = {$urandom, $urandom}; index_i = 13'($urandom);
    @(negedge clk);
    chk("R2 pulse", 64'(chk_valid_o), 64'd0);
    chk("R3 hold",  64'({pa0, oh0, pf0, ro0}),
        64'({line_pa_o, state_oh_o, par_fail_o, repl_order_o}));
  endtask

  function automatic logic [31:0] mk_hi(input logic [4:0] code, input logic [7:0] ro, input logic [31:0] rnd);
    logic [31:0] h = rnd;
    h[29:25] = code;
    h[21:14] = ro;
    return h;
  endfunction

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_err++; n_chk++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", n_err, n_chk);
          $finish;
        end
      end
    join_none
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset", 64'({chk_valid_o, state_oh_o, state_err_o, addr_err_o, par_fail_o}), 64'd0);
    chk("R1 reset pa", 64'({line_pa_o, repl_order_o, bank_o, set_o, state_code_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 64'({chk_valid_o, state_oh_o, line_pa_o[15:0]}), 64'd0);

    // Directed: every legal code, good and single-bad parity
    for (int s = 0; s < 6; s++) begin
      apply(mk_hi(legal_tab[s], 8'hE4, 32'h0), fix_par({24'h0, 40'hA5_5A3C_E000}, 0, 0), 13'h0A60);
      apply(mk_hi(legal_tab[s], 8'h1B, 32'h0), fix_par({24'h0, 40'h12_3456_6000}, 1, 0), 13'h1020);
      apply(mk_hi(legal_tab[s], 8'h39, 32'h0), fix_par({24'h0, 40'hFF_FFFF_E000}, 0, 1), 13'h1FFF);
    end
    // Illegal codes with broken parity: gating (R8)
    apply(mk_hi(5'h1F, 8'h00, 32'h0), fix_par(64'hFF_FFFF_E000, 1, 1), 13'h0000);
    apply(mk_hi(5'h10, 8'hFF, 32'hFFFF_FFFF), fix_par(64'h00_0000_2000, 1, 0), 13'h0020);
    apply(mk_hi(5'h01, 8'h5A, 32'h0), fix_par(64'h80_0000_0000, 0, 1), 13'h1000);
    hold_check();

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [4:0] c;
      logic [63:0] lo;
      c  = ($urandom_range(0, 3) != 0) ? legal_tab[$urandom_range(0, 5)] : 5'($urandom);
      lo = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1)
        lo = fix_par(lo, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      apply(mk_hi(c, 8'($urandom), $urandom), lo, 13'($urandom));
      if ($urandom_range(0, 4) == 0) hold_check();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule